// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block caches page translations in a fully associative array with a parameterised number of slots. Each slot carries a virtual page tag, a physical page number, an address-space identifier, a global flag, per-privilege-mode read and write enable masks, fault-on-read and fault-on-write flags, and a valid flag. A lookup presents a virtual page number and the current address-space identifier. In the same cycle, the block returns a hit flag and the fields of the matching slot.

New translations are written at a round-robin next-to-use pointer. Three maintenance commands remove entries: wipe everything, drop every non-global entry, or drop the entries that one page and address-space pair would hit. A separate index port shows the slot under the pointer, and can step the pointer without writing anything. Table walking, fault generation and statistics are left to the surrounding logic.

Top module: `asn_tlb`

## Requirements
- R1: A slot hits only when it is valid, its tag equals `lu_vpn_i`, and either its global flag is set or its stored identifier equals `lu_asn_i`.
- R2: Lookup is combinational. When several slots hit, the lowest-numbered one supplies the outputs. On a miss, `lu_hit_o` is 0 and every lookup field output is 0.
- R3: On `ins_i`, the slot at the pointer is overwritten at the next clock edge and marked valid, even if it already held a valid entry. Its tag is `ins_va_i[VA_W-1:OFF_W]`, so the page offset bits are dropped. The pointer then advances by one.
- R4: The next-to-use pointer steps from DEPTH-1 back to 0.
- R5: `flush_all_i` clears every slot (valid included) and sets the pointer to 0 at the next edge.
- R6: `flush_ng_i` invalidates every slot whose global flag is clear. Global slots and the pointer are left unchanged.
- R7: `flush_addr_i` invalidates every slot that a lookup of `fl_vpn_i`/`fl_asn_i` would hit under the R1 rule, global slots with a matching tag included. Other slots stay valid.
- R8: The index port shows the valid flag, tag, physical page, identifier and global flag of the slot under the pointer. With no insert or flush-all, the pointer moves by one only when `idx_adv_i` is high.
- R9: Only one command acts per cycle, in the priority order `flush_all_i` > `flush_addr_i` > `flush_ng_i` > `ins_i` > `idx_adv_i`. Lower-ranked commands in that cycle have no effect.
- R10: After reset, every slot is invalid, the pointer is 0 and no lookup hits.
- R11: A hit returns the read mask, write mask, fault-on-read flag and fault-on-write flag exactly as they were inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lu_vpn_i | input | VPN_W | Lookup virtual page number |
| lu_asn_i | input | ASN_W | Lookup address-space identifier |
| lu_hit_o | output | 1 | Lookup hit |
| lu_ppn_o | output | PPN_W | Physical page of hit slot |
| lu_glob_o | output | 1 | Global flag of hit slot |
| lu_rd_en_o | output | MODES | Per-mode read enables of hit slot |
| lu_wr_en_o | output | MODES | Per-mode write enables of hit slot |
| lu_fault_rd_o | output | 1 | Fault-on-read flag of hit slot |
| lu_fault_wr_o | output | 1 | Fault-on-write flag of hit slot |
| ins_i | input | 1 | Insert command |
| ins_va_i | input | VA_W | Virtual address of new entry |
| ins_ppn_i | input | PPN_W | Physical page of new entry |
| ins_asn_i | input | ASN_W | Identifier of new entry |
| ins_glob_i | input | 1 | Global flag of new entry |
| ins_rd_en_i | input | MODES | Read enables of new entry |
| ins_wr_en_i | input | MODES | Write enables of new entry |
| ins_fault_rd_i | input | 1 | Fault-on-read flag of new entry |
| ins_fault_wr_i | input | 1 | Fault-on-write flag of new entry |
| flush_all_i | input | 1 | Clear every slot |
| flush_ng_i | input | 1 | Drop non-global slots |
| flush_addr_i | input | 1 | Drop slots hit by fl_vpn_i/fl_asn_i |
| fl_vpn_i | input | VPN_W | Page for address flush |
| fl_asn_i | input | ASN_W | Identifier for address flush |
| idx_adv_i | input | 1 | Step the pointer |
| idx_ptr_o | output | IDX_W | Next-to-use pointer |
| idx_valid_o | output | 1 | Valid flag of slot under pointer |
| idx_tag_o | output | VPN_W | Tag of slot under pointer |
| idx_ppn_o | output | PPN_W | Physical page of slot under pointer |
| idx_asn_o | output | ASN_W | Identifier of slot under pointer |
| idx_glob_o | output | 1 | Global flag of slot under pointer |

## Verification
Lookups run against a filled array that deliberately holds duplicate tags. Some duplicates differ only in identifier and one duplicate is global. The table of probes therefore separates an identifier match, a global override, a tag mismatch and a multi-hit resolved to the lowest slot. The flush commands are each followed by lookups that keep global and non-global survivors apart. Commands are also applied in pairs, and the lower-ranked command is chosen so that its effect would show at the ports if it wrongly acted: an inserted global entry, or a stepped pointer.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  typedef enum logic [2:0] {
    OP_IDLE,
    OP_FLUSH_ALL,
    OP_FLUSH_ADDR,
    OP_FLUSH_NG,
    OP_INSERT,
    OP_ADVANCE
  } op_e;

  // One command per cycle, strongest first
  function automatic op_e pick_op(input logic fa, input logic fad,
                                  input logic fng, input logic ins,
                                  input logic adv);
    if (fa)       return OP_FLUSH_ALL;
    else if (fad) return OP_FLUSH_ADDR;
    else if (fng) return OP_FLUSH_NG;
    else if (ins) return OP_INSERT;
    else if (adv) return OP_ADVANCE;
    else          return OP_IDLE;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int DEPTH = 64,
  parameter int VPN_W = 30,
  parameter int ASN_W = 8
) (
  input  logic [DEPTH-1:0]            valid_i,
  input  logic [DEPTH-1:0]            glob_i,
  input  logic [DEPTH-1:0][VPN_W-1:0] tag_i,
  input  logic [DEPTH-1:0][ASN_W-1:0] asn_i,
  input  logic [VPN_W-1:0]            vpn_i,
  input  logic [ASN_W-1:0]            cur_asn_i,
  output logic [DEPTH-1:0]            match_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == vpn_i) &&
                        (glob_i[g] || (asn_i[g] == cur_asn_i));
  end
endmodule

// File: rtl/tlb_prio_sel.sv
module tlb_prio_sel #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DEPTH-1:0] req_i,
  output logic             hit_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign hit_o = |req_i;

  assert_lowest_wins_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (req_i[idx_o] && ((req_i & ((DEPTH'(1) << idx_o) - DEPTH'(1))) == '0)));
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int DEPTH = 64,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] ptr_o
);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clr_i)   ptr_q <= '0;
    else if (step_i)  ptr_q <= (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end
  assign ptr_o = ptr_q;

  assert_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !clr_i && ptr_q == IDX_W'(DEPTH - 1)) |=> (ptr_q == '0));
  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !clr_i) |=> $stable(ptr_q));
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import tlb_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int VPN_W = 30,
  parameter int OFF_W = 13,
  parameter int PPN_W = 28,
  parameter int ASN_W = 8,
  parameter int MODES = 4,
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lu_vpn_i,
  input  logic [ASN_W-1:0] lu_asn_i,
  output logic             lu_hit_o,
  output logic [PPN_W-1:0] lu_ppn_o,
  output logic             lu_glob_o,
  output logic [MODES-1:0] lu_rd_en_o,
  output logic [MODES-1:0] lu_wr_en_o,
  output logic             lu_fault_rd_o,
  output logic             lu_fault_wr_o,
  input  logic             ins_i,
  input  logic [VA_W-1:0]  ins_va_i,
  input  logic [PPN_W-1:0] ins_ppn_i,
  input  logic [ASN_W-1:0] ins_asn_i,
  input  logic             ins_glob_i,
  input  logic [MODES-1:0] ins_rd_en_i,
  input  logic [MODES-1:0] ins_wr_en_i,
  input  logic             ins_fault_rd_i,
  input  logic             ins_fault_wr_i,
  input  logic             flush_all_i,
  input  logic             flush_ng_i,
  input  logic             flush_addr_i,
  input  logic [VPN_W-1:0] fl_vpn_i,
  input  logic [ASN_W-1:0] fl_asn_i,
  input  logic             idx_adv_i,
  output logic [IDX_W-1:0] idx_ptr_o,
  output logic             idx_valid_o,
  output logic [VPN_W-1:0] idx_tag_o,
  output logic [PPN_W-1:0] idx_ppn_o,
  output logic [ASN_W-1:0] idx_asn_o,
  output logic             idx_glob_o
);
  logic [DEPTH-1:0]            valid_q, glob_q, frd_q, fwr_q;
  logic [DEPTH-1:0][VPN_W-1:0] tag_q;
  logic [DEPTH-1:0][PPN_W-1:0] ppn_q;
  logic [DEPTH-1:0][ASN_W-1:0] asn_q;
  logic [DEPTH-1:0][MODES-1:0] rd_q, wr_q;

  logic [DEPTH-1:0] lu_match, fl_match;
  logic [IDX_W-1:0] hit_idx, ptr;
  logic             hit;
  op_e              op;

  assign op = pick_op(flush_all_i, flush_addr_i, flush_ng_i, ins_i, idx_adv_i);

  tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lu_match (
    .valid_i(valid_q), .glob_i(glob_q), .tag_i(tag_q), .asn_i(asn_q),
    .vpn_i(lu_vpn_i), .cur_asn_i(lu_asn_i), .match_o(lu_match));

  tlb_match #(.DEPTH(DEPTH), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_match (
    .valid_i(valid_q), .glob_i(glob_q), .tag_i(tag_q), .asn_i(asn_q),
    .vpn_i(fl_vpn_i), .cur_asn_i(fl_asn_i), .match_o(fl_match));

  tlb_prio_sel #(.DEPTH(DEPTH)) u_sel (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(lu_match), .hit_o(hit), .idx_o(hit_idx));

  tlb_rr_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(op == OP_FLUSH_ALL),
    .step_i(op == OP_INSERT || op == OP_ADVANCE), .ptr_o(ptr));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0; glob_q <= '0; frd_q <= '0; fwr_q <= '0;
      tag_q <= '0; ppn_q <= '0; asn_q <= '0; rd_q <= '0; wr_q <= '0;
    end else begin
      unique case (op)
        OP_FLUSH_ALL: begin
          valid_q <= '0; glob_q <= '0; frd_q <= '0; fwr_q <= '0;
          tag_q <= '0; ppn_q <= '0; asn_q <= '0; rd_q <= '0; wr_q <= '0;
        end
        OP_FLUSH_ADDR: valid_q <= valid_q & ~fl_match;
        OP_FLUSH_NG:   valid_q <= valid_q & glob_q;
        OP_INSERT: begin
          valid_q[ptr] <= 1'b1;
          tag_q[ptr]   <= ins_va_i[VA_W-1:OFF_W];
          ppn_q[ptr]   <= ins_ppn_i;
          asn_q[ptr]   <= ins_asn_i;
          glob_q[ptr]  <= ins_glob_i;
          rd_q[ptr]    <= ins_rd_en_i;
          wr_q[ptr]    <= ins_wr_en_i;
          frd_q[ptr]   <= ins_fault_rd_i;
          fwr_q[ptr]   <= ins_fault_wr_i;
        end
        default: ;
      endcase
    end
  end

  // Fields forced to zero on a miss
  assign lu_hit_o      = hit;
  assign lu_ppn_o      = hit ? ppn_q[hit_idx] : '0;
  assign lu_glob_o     = hit & glob_q[hit_idx];
  assign lu_rd_en_o    = hit ? rd_q[hit_idx] : '0;
  assign lu_wr_en_o    = hit ? wr_q[hit_idx] : '0;
  assign lu_fault_rd_o = hit & frd_q[hit_idx];
  assign lu_fault_wr_o = hit & fwr_q[hit_idx];

  assign idx_ptr_o   = ptr;
  assign idx_valid_o = valid_q[ptr];
  assign idx_tag_o   = tag_q[ptr];
  assign idx_ppn_o   = ppn_q[ptr];
  assign idx_asn_o   = asn_q[ptr];
  assign idx_glob_o  = glob_q[ptr];

  assert_hit_rule_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lu_hit_o |-> (valid_q[hit_idx] && tag_q[hit_idx] == lu_vpn_i &&
                  (glob_q[hit_idx] || asn_q[hit_idx] == lu_asn_i)));
  assert_insert_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_INSERT) |=> (valid_q[$past(ptr)] &&
                           tag_q[$past(ptr)] == $past(ins_va_i[VA_W-1:OFF_W])));
  assert_flush_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_FLUSH_ALL) |=> (valid_q == '0 && ptr == '0));
  assert_flush_ng_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_FLUSH_NG) |=> ((valid_q & ~glob_q) == '0 &&
                             (valid_q & glob_q) == $past(valid_q & glob_q)));
  assert_flush_addr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op == OP_FLUSH_ADDR) |=> ((valid_q & $past(fl_match)) == '0));
endmodule

// File: tb/asn_tlb_tb.sv
module asn_tlb_tb;
  localparam int DEPTH = 8;
  localparam int VPN_W = 30;
  localparam int OFF_W = 13;
  localparam int PPN_W = 28;
  localparam int ASN_W = 8;
  localparam int MODES = 4;
  localparam int VA_W  = VPN_W + OFF_W;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 1'b0, rst_ni = 1'b0;
  always #2 clk = ~clk;

  logic [VPN_W-1:0] lu_vpn = '0, fl_vpn = '0;
  logic [ASN_W-1:0] lu_asn = '0, fl_asn = '0, ins_asn = '0;
  logic lu_hit, lu_glob, lu_frd, lu_fwr;
  logic [PPN_W-1:0] lu_ppn, idx_ppn, ins_ppn = '0;
  logic [MODES-1:0] lu_rd, lu_wr, ins_rd = '0, ins_wr = '0;
  logic ins = 0, ins_glob = 0, ins_frd = 0, ins_fwr = 0;
  logic [VA_W-1:0] ins_va = '0;
  logic f_all = 0, f_ng = 0, f_addr = 0, adv = 0;
  logic [IDX_W-1:0] idx_ptr;
  logic idx_valid, idx_glob;
  logic [VPN_W-1:0] idx_tag;
  logic [ASN_W-1:0] idx_asn;

  asn_tlb #(.DEPTH(DEPTH), .VPN_W(VPN_W), .OFF_W(OFF_W), .PPN_W(PPN_W),
            .ASN_W(ASN_W), .MODES(MODES)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .lu_vpn_i(lu_vpn), .lu_asn_i(lu_asn),
    .lu_hit_o(lu_hit), .lu_ppn_o(lu_ppn), .lu_glob_o(lu_glob),
    .lu_rd_en_o(lu_rd), .lu_wr_en_o(lu_wr), .lu_fault_rd_o(lu_frd),
    .lu_fault_wr_o(lu_fwr), .ins_i(ins), .ins_va_i(ins_va), .ins_ppn_i(ins_ppn),
    .ins_asn_i(ins_asn), .ins_glob_i(ins_glob), .ins_rd_en_i(ins_rd),
    .ins_wr_en_i(ins_wr), .ins_fault_rd_i(ins_frd), .ins_fault_wr_i(ins_fwr),
    .flush_all_i(f_all), .flush_ng_i(f_ng), .flush_addr_i(f_addr),
    .fl_vpn_i(fl_vpn), .fl_asn_i(fl_asn), .idx_adv_i(adv), .idx_ptr_o(idx_ptr),
    .idx_valid_o(idx_valid), .idx_tag_o(idx_tag), .idx_ppn_o(idx_ppn),
    .idx_asn_o(idx_asn), .idx_glob_o(idx_glob));

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a);
    lu_vpn = v; lu_asn = a; #1;
  endtask

  // Drive at negedge, let one edge act, sample after it
  task automatic tick();
    @(posedge clk); #1;
    ins = 0; f_all = 0; f_ng = 0; f_addr = 0; adv = 0;
    @(negedge clk);
  endtask

  task automatic put(input logic [VPN_W-1:0] v, input logic [ASN_W-1:0] a,
                     input logic g, input logic [PPN_W-1:0] p,
                     input logic [MODES-1:0] rd, input logic [MODES-1:0] wr,
                     input logic fr, input logic fw);
    ins = 1; ins_va = {v, 13'h0a5}; ins_asn = a; ins_glob = g; ins_ppn = p;
    ins_rd = rd; ins_wr = wr; ins_frd = fr; ins_fwr = fw;
  endtask

  typedef struct packed {
    logic [VPN_W-1:0] vpn;
    logic [ASN_W-1:0] asn;
    logic             hit;
    logic [PPN_W-1:0] ppn;
  } vec_t;

  // Slots: 0..5 tag 40+k asn k (5 global), 6 tag 41 asn 6, 7 tag 42 global
  localparam vec_t VEC [11] = '{
    '{30'h40, 8'd0,  1'b1, 28'h200},  // R1 asn match
    '{30'h40, 8'd1,  1'b0, 28'h0},    // R1 asn mismatch, R2 zero fields
    '{30'h41, 8'd1,  1'b1, 28'h201},
    '{30'h41, 8'd6,  1'b1, 28'h206},  // R1 duplicate tag, other asn
    '{30'h41, 8'd3,  1'b0, 28'h0},
    '{30'h42, 8'd2,  1'b1, 28'h202},  // R2 two hits, lowest wins
    '{30'h42, 8'd9,  1'b1, 28'h207},  // R1 global override
    '{30'h45, 8'd0,  1'b1, 28'h205},
    '{30'h45, 8'd77, 1'b1, 28'h205},
    '{30'h46, 8'd0,  1'b0, 28'h0},    // R1 tag mismatch
    '{30'h43, 8'd3,  1'b1, 28'h203}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    look('0, '0);
    chk("R10 hit", lu_hit, 0);
    chk("R10 ptr", idx_ptr, 0);
    chk("R10 valid", idx_valid, 0);
    rst_ni = 1; @(negedge clk);

    for (int k = 0; k < DEPTH; k++) begin
      logic [VPN_W-1:0] v;
      v = (k == 6) ? 30'h41 : (k == 7) ? 30'h42 : VPN_W'(30'h40 + k);
      put(v, ASN_W'(k), (k == 5 || k == 7), PPN_W'(28'h200 + k),
          MODES'(k), ~MODES'(k), k[0], k[1]);
      tick();
    end
    // R4 wrap after DEPTH inserts; R8 index port at slot 0
    chk("R4 ptr wrapped", idx_ptr, 0);
    chk("R8 idx valid", idx_valid, 1);
    chk("R8 idx tag", idx_tag, 30'h40);
    chk("R8 idx ppn", idx_ppn, 28'h200);

    for (int i = 0; i < 11; i++) begin
      look(VEC[i].vpn, VEC[i].asn);
      chk($sformatf("R1/R2 vec%0d hit", i), lu_hit, VEC[i].hit);
      chk($sformatf("R1/R2 vec%0d ppn", i), lu_ppn, VEC[i].ppn);
    end

    // R11 attributes of slot 3
    look(30'h43, 8'd3);
    chk("R11 rd", lu_rd, 4'h3);
    chk("R11 wr", lu_wr, 4'hc);
    chk("R11 frd", lu_frd, 1);
    chk("R11 fwr", lu_fwr, 1);
    chk("R11 glob", lu_glob, 0);
    look(30'h40, 8'd1);
    chk("R2 miss rd zero", lu_rd, 0);

    // R8 hold without advance, then step
    tick();
    chk("R8 hold", idx_ptr, 0);
    adv = 1; tick();
    chk("R8 adv ptr", idx_ptr, 1);
    chk("R8 adv tag", idx_tag, 30'h41);
    chk("R8 adv asn", idx_asn, 1);

    // R3 overwrite slot 1; offset bits must not reach tag
    put(30'h50, 8'd1, 0, 28'h250, 4'h1, 4'h1, 0, 0); tick();
    chk("R3 ptr step", idx_ptr, 2);
    look(30'h41, 8'd1); chk("R3 old entry gone", lu_hit, 0);
    look(30'h50, 8'd1); chk("R3 new hit", lu_hit, 1);
    chk("R3 new ppn", lu_ppn, 28'h250);

    // R7 address flush of 42/asn2 removes slot 2 and global slot 7
    fl_vpn = 30'h42; fl_asn = 8'd2; f_addr = 1; tick();
    look(30'h42, 8'd2); chk("R7 asn entry gone", lu_hit, 0);
    look(30'h42, 8'd9); chk("R7 global entry gone", lu_hit, 0);
    look(30'h43, 8'd3); chk("R7 other kept", lu_hit, 1);

    // R6 + R9: flush_ng beats a global insert
    f_ng = 1; put(30'h60, 8'd0, 1, 28'h260, 0, 0, 0, 0); tick();
    chk("R9 ptr not stepped", idx_ptr, 2);
    look(30'h60, 8'd0); chk("R9 insert ignored", lu_hit, 0);
    look(30'h45, 8'd3); chk("R6 global kept", lu_hit, 1);
    look(30'h40, 8'd0); chk("R6 nonglobal gone", lu_hit, 0);
    look(30'h50, 8'd1); chk("R6 nonglobal gone2", lu_hit, 0);

    // R5 + R9: flush_all beats insert and advance
    f_all = 1; adv = 1; put(30'h61, 8'd0, 1, 28'h261, 0, 0, 0, 0); tick();
    chk("R5 ptr zero", idx_ptr, 0);
    chk("R5 slot0 invalid", idx_valid, 0);
    look(30'h45, 8'd5); chk("R5 global gone", lu_hit, 0);
    look(30'h61, 8'd0); chk("R9 insert ignored", lu_hit, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule